// File: doc/BRIEF.md
# SD Slot Card Detect, Power and Wake-Up Control

This block manages one SD host slot's presence detection, supply switching and wake-up signalling. A raw card-detect pin is synchronized and combined with a test override into one effective presence signal. Each change of that signal produces a one-cycle insertion or removal pulse. These pulses feed the interrupt status logic elsewhere.

Software writes a bus-power bit and a 3-bit voltage code through a single write strobe. The hardware clears the power bit by itself when the synchronized detect pin falls, which gives hot-removal support. A power sequencer turns the bit into pad controls:
- `PS_OFF`: everything is off.
- `PS_ON`: the supply is enabled and the bus is driven.
- `PS_DRAIN`: the supply is still on, but the clock, CMD and DAT lines are forced low for `DRAIN_CYCLES` cycles before the supply drops.

The transitions are:
- `PS_OFF`→`PS_ON` when the power bit is set.
- `PS_ON`→`PS_DRAIN` when the power bit is cleared.
- `PS_DRAIN`→`PS_OFF` when the drain counter expires.

A sticky wake-up request collects gated removal, insertion and card-interrupt events until it is cleared.

Top module: `sd_slot_power_ctrl`

## Requirements
- R1: After reset, every output is 0: no card present, no pulses, power bit 0, voltage code 000, supply off, bus not driven, no hold-low and no wake request.
- R2: With `det_sel`=0, `card_present` takes the value of `cd_pin` three rising edges after the pin changes (two synchronizer flops plus one presence register).
- R3: With `det_sel`=1, `card_present` takes the value of `det_test_lvl` (1 = card inserted, 0 = no card) one edge later, and `cd_pin` has no effect on it.
- R4: A 0→1 change of `card_present` raises `ins_evt` for exactly the first cycle of the new level. A 1→0 change raises `rem_evt` in the same way. The two pulses are never high together.
- R5: A cycle with `cfg_wr`=1 loads `cfg_pwr` into `pwr_bit` and `cfg_volt` into `pad_volt` at the next edge. `pad_volt` reflects the stored code unchanged: 101 = 1.8 V, 110 = 3.0 V, 111 = 3.3 V, and 000–100 are reserved.
- R6: A high-to-low transition of the synchronized detect pin clears `pwr_bit` one edge after the synchronizer output falls. This happens whatever `det_sel` is, and it overrides a `cfg_wr` in the same cycle.
- R7: In `PS_OFF`, one edge after `pwr_bit` is 1 the sequencer enters `PS_ON`, where `pad_pwr_en`=1, `bus_drv_en`=1 and `bus_hold_low`=0.
- R8: In `PS_ON`, one edge after `pwr_bit` is 0 the sequencer enters `PS_DRAIN` for `DRAIN_CYCLES` cycles (default 2), then enters `PS_OFF`. In `PS_DRAIN`, `bus_drv_en`=0, `bus_hold_low`=1 and `pad_pwr_en`=1. The supply never drops without a hold-low cycle just before it.
- R9: `wake_req` is set at the edge after any of these is true: `rem_evt` with `wake_en_rem`, `ins_evt` with `wake_en_ins`, or `card_irq` with `wake_en_irq`. A source whose enable is 0 has no effect.
- R10: `wake_req` stays 1 until a cycle with `wake_clr`=1 and no new set condition. A set condition in the same cycle as `wake_clr` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cd_pin | input | 1 | Raw card-detect pin, 1 = card present |
| det_sel | input | 1 | Detect source: 0 = pin, 1 = test level |
| det_test_lvl | input | 1 | Test presence level |
| cfg_wr | input | 1 | Write strobe for power bit and voltage code |
| cfg_pwr | input | 1 | Bus-power value to write |
| cfg_volt | input | 3 | Voltage code to write |
| wake_en_rem | input | 1 | Wake enable for removal |
| wake_en_ins | input | 1 | Wake enable for insertion |
| wake_en_irq | input | 1 | Wake enable for card interrupt |
| card_irq | input | 1 | Card interrupt event |
| wake_clr | input | 1 | Wake-up acknowledge |
| card_present | output | 1 | Effective card presence |
| ins_evt | output | 1 | Insertion pulse |
| rem_evt | output | 1 | Removal pulse |
| pwr_bit | output | 1 | Current bus-power bit |
| pad_volt | output | 3 | Voltage code to the pad |
| pad_pwr_en | output | 1 | Supply enable |
| bus_drv_en | output | 1 | Clock/CMD/DAT actively driven |
| bus_hold_low | output | 1 | Clock/CMD/DAT forced low |
| wake_req | output | 1 | Sticky wake-up request |

## Verification
The assertions check the following on every cycle:
- The insertion and removal pulses are exclusive, last one cycle and agree with the presence level.
- The bus is never driven and held low at once, and it is never driven without supply.
- The supply only falls right after a hold-low cycle.
- The wake request holds until it is acknowledged.
- The presence signal follows the test level in test mode.

Only the bench scenarios can show the rest:
- The synchronizer latency.
- The hot-removal clear winning over a simultaneous write.
- The exact drain length.
- Each wake source being ignored while disabled.

// File: rtl/sd_slot_pkg.sv
package sd_slot_pkg;

    typedef enum logic [1:0] {
        PS_OFF   = 2'd0,
        PS_ON    = 2'd1,
        PS_DRAIN = 2'd2
    } pwr_state_t;

    localparam int VOLT_W = 3;

    typedef struct packed {
        logic             pwr;
        logic [VOLT_W-1:0] volt;
    } slot_cfg_t;

endpackage

// File: rtl/slot_detect.sv
module slot_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cd_pin,
    input  logic det_sel,
    input  logic det_test_lvl,
    output logic present,
    output logic ins_evt,
    output logic rem_evt,
    output logic pin_fall
);

    logic [SYNC_STAGES-1:0] chain;
    logic                   pin_sync;
    logic                   pin_d;
    logic                   pres_r;
    logic                   pres_d;
    logic                   eff;

    // synchronizer chain, length set by parameter
    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= cd_pin;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[SYNC_STAGES-2:0], cd_pin};
            end
        end
    endgenerate

    assign pin_sync = chain[SYNC_STAGES-1];

    always_comb begin
        eff = det_sel ? det_test_lvl : pin_sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_d  <= 1'b0;
            pres_r <= 1'b0;
            pres_d <= 1'b0;
        end else begin
            pin_d  <= pin_sync;
            pres_r <= eff;
            pres_d <= pres_r;
        end
    end

    assign present  = pres_r;
    assign ins_evt  = pres_r & ~pres_d;
    assign rem_evt  = ~pres_r & pres_d;
    assign pin_fall = pin_d & ~pin_sync;

endmodule

// File: rtl/slot_cfg_reg.sv
module slot_cfg_reg
    import sd_slot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              wr_pwr,
    input  logic [VOLT_W-1:0] wr_volt,
    input  logic              hot_remove,
    output slot_cfg_t         cfg
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
        end else begin
            if (wr) cfg.volt <= wr_volt;
            // hot removal wins over a concurrent write
            if (hot_remove)  cfg.pwr <= 1'b0;
            else if (wr)     cfg.pwr <= wr_pwr;
        end
    end

endmodule

// File: rtl/slot_power_fsm.sv
module slot_power_fsm
    import sd_slot_pkg::*;
#(
    parameter int DRAIN_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_req,
    output logic pad_pwr_en,
    output logic bus_drv_en,
    output logic bus_hold_low
);

    localparam int CW = (DRAIN_CYCLES > 1) ? $clog2(DRAIN_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(DRAIN_CYCLES - 1);

    pwr_state_t      state, state_nx;
    logic [CW-1:0]   cnt, cnt_nx;

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            PS_OFF: begin
                if (pwr_req) state_nx = PS_ON;
            end
            PS_ON: begin
                if (!pwr_req) begin
                    state_nx = PS_DRAIN;
                    cnt_nx   = '0;
                end
            end
            PS_DRAIN: begin
                if (cnt == LAST) state_nx = PS_OFF;
                else             cnt_nx   = cnt + 1'b1;
            end
            default: state_nx = PS_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PS_OFF;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        pad_pwr_en   = 1'b0;
        bus_drv_en   = 1'b0;
        bus_hold_low = 1'b0;
        unique case (state)
            PS_OFF:   ;
            PS_ON: begin
                pad_pwr_en = 1'b1;
                bus_drv_en = 1'b1;
            end
            PS_DRAIN: begin
                pad_pwr_en   = 1'b1;
                bus_hold_low = 1'b1;
            end
            default:  ;
        endcase
    end

endmodule

// File: rtl/slot_wake.sv
module slot_wake #(
    parameter int N_SRC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt,
    input  logic [N_SRC-1:0] en,
    input  logic             clr,
    output logic             req
);

    logic [N_SRC-1:0] gated;
    logic             any_set;

    genvar i;
    generate
        for (i = 0; i < N_SRC; i++) begin : g_gate
            assign gated[i] = evt[i] & en[i];
        end
    endgenerate

    assign any_set = |gated;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       req <= 1'b0;
        else if (any_set) req <= 1'b1;
        else if (clr)     req <= 1'b0;
    end

endmodule

// File: rtl/sd_slot_power_ctrl.sv
module sd_slot_power_ctrl
    import sd_slot_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int DRAIN_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cd_pin,
    input  logic       det_sel,
    input  logic       det_test_lvl,
    input  logic       cfg_wr,
    input  logic       cfg_pwr,
    input  logic [2:0] cfg_volt,
    input  logic       wake_en_rem,
    input  logic       wake_en_ins,
    input  logic       wake_en_irq,
    input  logic       card_irq,
    input  logic       wake_clr,
    output logic       card_present,
    output logic       ins_evt,
    output logic       rem_evt,
    output logic       pwr_bit,
    output logic [2:0] pad_volt,
    output logic       pad_pwr_en,
    output logic       bus_drv_en,
    output logic       bus_hold_low,
    output logic       wake_req
);

    logic      pin_fall;
    slot_cfg_t cfg;

    slot_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det (
        .clk          (clk),
        .rst_n        (rst_n),
        .cd_pin       (cd_pin),
        .det_sel      (det_sel),
        .det_test_lvl (det_test_lvl),
        .present      (card_present),
        .ins_evt      (ins_evt),
        .rem_evt      (rem_evt),
        .pin_fall     (pin_fall)
    );

    slot_cfg_reg u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (cfg_wr),
        .wr_pwr     (cfg_pwr),
        .wr_volt    (cfg_volt),
        .hot_remove (pin_fall),
        .cfg        (cfg)
    );

    assign pwr_bit  = cfg.pwr;
    assign pad_volt = cfg.volt;

    slot_power_fsm #(.DRAIN_CYCLES(DRAIN_CYCLES)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwr_req      (cfg.pwr),
        .pad_pwr_en   (pad_pwr_en),
        .bus_drv_en   (bus_drv_en),
        .bus_hold_low (bus_hold_low)
    );

    slot_wake #(.N_SRC(3)) u_wake (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   ({card_irq, ins_evt, rem_evt}),
        .en    ({wake_en_irq, wake_en_ins, wake_en_rem}),
        .clr   (wake_clr),
        .req   (wake_req)
    );

endmodule

// File: rtl/slot_power_chk.sv
module slot_power_chk (
    input logic clk,
    input logic rst_n,
    input logic det_sel,
    input logic det_test_lvl,
    input logic wake_clr,
    input logic card_present,
    input logic ins_evt,
    input logic rem_evt,
    input logic pad_pwr_en,
    input logic bus_drv_en,
    input logic bus_hold_low,
    input logic wake_req
);

    assert_pulse_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ins_evt, rem_evt}));

    assert_ins_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ins_evt |-> card_present);

    assert_rem_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rem_evt |-> !card_present);

    assert_ins_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ins_evt |=> !ins_evt);

    assert_test_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        det_sel |=> (card_present == $past(det_test_lvl)));

    assert_drive_vs_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_drv_en && bus_hold_low));

    assert_drive_needs_supply_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_drv_en |-> pad_pwr_en);

    assert_low_before_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pad_pwr_en |=> (pad_pwr_en || $past(bus_hold_low)));

    assert_wake_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req && !wake_clr) |=> wake_req);

endmodule

bind sd_slot_power_ctrl slot_power_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .det_sel      (det_sel),
    .det_test_lvl (det_test_lvl),
    .wake_clr     (wake_clr),
    .card_present (card_present),
    .ins_evt      (ins_evt),
    .rem_evt      (rem_evt),
    .pad_pwr_en   (pad_pwr_en),
    .bus_drv_en   (bus_drv_en),
    .bus_hold_low (bus_hold_low),
    .wake_req     (wake_req)
);

// File: tb/sim_sd_slot_power_ctrl.sv
`timescale 1ns/1ps
module sim_sd_slot_power_ctrl;

    localparam int DRAIN = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cd_pin = 0, det_sel = 0, det_test_lvl = 0, cfg_wr = 0, cfg_pwr = 0;
    logic [2:0] cfg_volt = 0;
    logic wake_en_rem = 0, wake_en_ins = 0, wake_en_irq = 0, card_irq = 0, wake_clr = 0;
    logic card_present, ins_evt, rem_evt, pwr_bit, pad_pwr_en, bus_drv_en, bus_hold_low, wake_req;
    logic [2:0] pad_volt;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    sd_slot_power_ctrl #(.SYNC_STAGES(2), .DRAIN_CYCLES(DRAIN)) u0 (.*);

    // reference model state
    logic m_s1, m_s2, m_pind, m_pres, m_presd, m_pwr, m_wake;
    logic [2:0] m_volt;
    int m_st, m_cnt;

    function automatic logic f_ins(logic p, logic d); return p & ~d; endfunction
    function automatic logic f_rem(logic p, logic d); return ~p & d; endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_s1 = 0; m_s2 = 0; m_pind = 0; m_pres = 0; m_presd = 0;
        m_pwr = 0; m_wake = 0; m_volt = 0; m_st = 0; m_cnt = 0;
    endtask

    task automatic model_edge();
        logic ins, rem, fall, set, eff;
        ins  = f_ins(m_pres, m_presd);
        rem  = f_rem(m_pres, m_presd);
        fall = m_pind & ~m_s2;
        eff  = det_sel ? det_test_lvl : m_s2;
        set  = (rem & wake_en_rem) | (ins & wake_en_ins) | (card_irq & wake_en_irq);
        // power sequencer uses the old power bit
        case (m_st)
            0: if (m_pwr) m_st = 1;
            1: if (!m_pwr) begin m_st = 2; m_cnt = 0; end
            default: if (m_cnt == DRAIN - 1) m_st = 0; else m_cnt++;
        endcase
        if (set) m_wake = 1; else if (wake_clr) m_wake = 0;
        if (cfg_wr) m_volt = cfg_volt;
        if (fall) m_pwr = 0; else if (cfg_wr) m_pwr = cfg_pwr;
        m_presd = m_pres; m_pres = eff;
        m_pind = m_s2; m_s2 = m_s1; m_s1 = cd_pin;
    endtask

    task automatic compare();
        chk(det_sel ? "R3" : "R2", card_present, m_pres);
        chk("R4", ins_evt, f_ins(m_pres, m_presd));
        chk("R4", rem_evt, f_rem(m_pres, m_presd));
        chk("R6", pwr_bit, m_pwr);
        chk("R5", pad_volt, m_volt);
        chk("R7", pad_pwr_en, m_st != 0);
        chk("R7", bus_drv_en, m_st == 1);
        chk("R8", bus_hold_low, m_st == 2);
        chk("R9", wake_req, m_wake);
    endtask

    // inputs are changed at negedge; one step = one rising edge
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    initial begin
        #2000000;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250611));
        model_reset();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", {card_present, ins_evt, rem_evt, pwr_bit, pad_volt, pad_pwr_en,
                   bus_drv_en, bus_hold_low, wake_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: pin insertion after three edges, R4 insertion pulse
        cd_pin = 1; wake_en_rem = 1;
        step(); step();
        chk("R2", card_present, 0);
        step();
        chk("R2", card_present, 1);
        chk("R4", ins_evt, 1);
        step();
        chk("R4", ins_evt, 0);

        // R5 write power and 1.8 V code
        cfg_wr = 1; cfg_pwr = 1; cfg_volt = 3'b101;
        step();
        cfg_wr = 0;
        chk("R5", pwr_bit, 1); chk("R5", pad_volt, 3'b101);
        step();
        chk("R7", pad_pwr_en, 1); chk("R7", bus_drv_en, 1);

        // R6 hot removal, with a conflicting write on the clearing cycle
        cd_pin = 0;
        step(); step();
        cfg_wr = 1; cfg_pwr = 1; cfg_volt = 3'b111;
        step();
        cfg_wr = 0;
        chk("R6", pwr_bit, 0);
        chk("R5", pad_volt, 3'b111);
        chk("R4", rem_evt, 1);
        step();
        chk("R8", bus_hold_low, 1); chk("R8", pad_pwr_en, 1); chk("R8", bus_drv_en, 0);
        chk("R9", wake_req, 1);
        step();
        chk("R8", bus_hold_low, 1);
        step();
        chk("R8", pad_pwr_en, 0); chk("R8", bus_hold_low, 0);

        // R10 acknowledge clears, then set wins over clear
        wake_clr = 1;
        step();
        chk("R10", wake_req, 0);
        card_irq = 1; wake_en_irq = 1;
        step();
        chk("R10", wake_req, 1);
        card_irq = 0; wake_clr = 0; wake_en_irq = 0;

        // R9 disabled source ignored
        wake_clr = 1; step(); wake_clr = 0;
        card_irq = 1; step(); step(); card_irq = 0;
        chk("R9", wake_req, 0);

        // R3 test mode ignores the pin
        det_sel = 1; det_test_lvl = 1; cd_pin = 0;
        step();
        chk("R3", card_present, 1);
        cd_pin = 1; step(); step(); step();
        det_test_lvl = 0; step();
        chk("R3", card_present, 0);

        // constrained random phase
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 9 == 0)  cd_pin = ~cd_pin;
            if ($urandom % 40 == 0) det_sel = ~det_sel;
            if ($urandom % 7 == 0)  det_test_lvl = ~det_test_lvl;
            cfg_wr   = ($urandom % 6 == 0);
            cfg_pwr  = ($urandom % 3 != 0);
            cfg_volt = 3'($urandom);
            card_irq = ($urandom % 10 == 0);
            wake_clr = ($urandom % 5 == 0);
            if (i % 50 == 0) begin
                wake_en_rem = 1'($urandom);
                wake_en_ins = 1'($urandom);
                wake_en_irq = 1'($urandom);
            end
            step();
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule